// File: doc/BRIEF.md
# Indirect Addressing Pointer Unit

This block keeps three 12-bit pointers into data memory and turns them into addresses for indirect reads and writes. On each access the caller picks a pointer and an access mode. Depending on the mode, the address is the pointer itself, the pointer plus one, or the pointer plus a signed 8-bit offset taken from the working register. The same access may also step the pointer up or down by one. The address and its valid flag are registered and appear one cycle after the strobe.

Software reaches each pointer in two ways. It can write the pointer as a low byte and a high byte, or it can load all 12 bits at once with a single command. A registered read port returns either byte of any pointer. All pointer arithmetic wraps modulo 4096. Any change to a pointer takes effect at the clock edge that ends the access, so accesses issued back to back see consecutive addresses.

Top module: `ptr_addr_unit`

## Requirements
- R1: After a synchronous reset all three pointers hold 0x000. In the first cycle after reset, addr_vld is 0 and rd_data is 0x00.
- R2: A cycle with ld_en high and wr_sel in 0..2 replaces all 12 bits of that pointer with ld_val. The next access to that pointer uses the new value.
- R3: A byte write (wr_en high, with wr_sel in 0..2) changes only one part of the pointer. With wr_hi=1 it writes wr_data[3:0] into bits 11:8. With wr_hi=0 it writes wr_data into bits 7:0. The other bits stay unchanged.
- R4: One cycle after rd_sel/rd_hi are presented, rd_data returns the selected byte of the pointer as it stood before that edge. rd_hi=1 gives bits 11:8 in rd_data[3:0], and rd_data[7:4] always reads 0. rd_hi=0 gives bits 7:0.
- R5: When acc_en is high and acc_sel is in 0..2, addr_vld is 1 in the next cycle and addr_out holds the effective address. Otherwise addr_vld is 0 in the next cycle.
- R6: Mode 0 (plain), and the unused codes 5 to 7, use the pointer value as the address and leave the pointer unchanged.
- R7: Mode 1 (post-increment) uses the current pointer value as the address and then adds 1 to the pointer. Back-to-back accesses therefore give consecutive addresses.
- R8: Mode 2 (post-decrement) uses the current pointer value as the address and then subtracts 1 from the pointer.
- R9: Mode 3 (pre-increment) adds 1 to the pointer and uses the new value as the address.
- R10: Mode 4 (offset) adds wreg, read as a signed 8-bit value, to the pointer to form the address. The pointer itself does not change.
- R11: Every sum and difference wraps modulo 4096. For example, 0x000 minus 1 gives 0xFFF, and 0xFFF plus 1 gives 0x000.
- R12: When several writes hit the same pointer in one cycle, the priority is: full load, then byte write, then the update from the access mode. The address produced in that cycle is still computed from the pointer value before the edge.
- R13: A select value of 3 is ignored everywhere. An access with acc_sel=3 raises no addr_vld. A load or byte write with wr_sel=3 changes no pointer. A read with rd_sel=3 returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| acc_en | input | 1 | Access strobe |
| acc_sel | input | 2 | Pointer used by the access |
| acc_mode | input | 3 | Access mode: 0 plain, 1 post-increment, 2 post-decrement, 3 pre-increment, 4 offset |
| wreg | input | 8 | Working register value, used as the signed offset in mode 4 |
| ld_en | input | 1 | Load all 12 bits of the pointer chosen by wr_sel |
| wr_en | input | 1 | Byte write strobe |
| wr_hi | input | 1 | Byte write target: 1 for the high byte, 0 for the low byte |
| wr_sel | input | 2 | Pointer targeted by a load or a byte write |
| wr_data | input | 8 | Data for a byte write |
| ld_val | input | 12 | Value for a full load |
| rd_sel | input | 2 | Pointer to read back |
| rd_hi | input | 1 | Read byte: 1 for the high byte, 0 for the low byte |
| addr_out | output | 12 | Registered effective address |
| addr_vld | output | 1 | addr_out is valid |
| rd_data | output | 8 | Registered read-back byte |

## Verification
The access path and the software write path can hit the same pointer in one clock edge. Examples are a post-increment arriving with a full load, or a post-decrement arriving with a low-byte write. The bench drives these pairs on purpose in directed cycles, and also lets a random stretch draw both strobes together often. In each collision the bench checks two things. First, the address leaving the block must come from the old pointer value. Second, the pointer value read back afterwards must be the one the priority order dictates. That value is confirmed by a plain access and by byte reads.

// File: rtl/ptr_pkg.sv
package ptr_pkg;
  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    AM_PLAIN   = 3'd0,
    AM_POSTINC = 3'd1,
    AM_POSTDEC = 3'd2,
    AM_PREINC  = 3'd3,
    AM_OFFSET  = 3'd4
  } acc_mode_e;
endpackage

// File: rtl/ptr_calc.sv
module ptr_calc #(
  parameter int AW = 12,
  parameter int DW = 8
) (
  input  logic [AW-1:0]             cur,
  input  logic [ptr_pkg::MODE_W-1:0] mode,
  input  logic [DW-1:0]             wreg,
  output logic [AW-1:0]             ea,
  output logic [AW-1:0]             nxt,
  output logic                      upd
);
  import ptr_pkg::*;

  localparam int EXT = AW - DW;

  logic [AW-1:0] inc_v;
  logic [AW-1:0] dec_v;
  logic [AW-1:0] ofs_v;

  assign inc_v = cur + AW'(1);
  assign dec_v = cur - AW'(1);
  assign ofs_v = cur + {{EXT{wreg[DW-1]}}, wreg};

  always_comb begin
    ea  = cur;
    nxt = cur;
    upd = 1'b0;
    case (acc_mode_e'(mode))
      AM_POSTINC: begin nxt = inc_v; upd = 1'b1; end
      AM_POSTDEC: begin nxt = dec_v; upd = 1'b1; end
      AM_PREINC:  begin ea = inc_v; nxt = inc_v; upd = 1'b1; end
      AM_OFFSET:  ea = ofs_v;
      default:    ea = cur;
    endcase
  end
endmodule

// File: rtl/ptr_reg.sv
module ptr_reg #(
  parameter int AW = 12,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld,
  input  logic [AW-1:0] ld_val,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic [DW-1:0] wr_data,
  input  logic          upd,
  input  logic [AW-1:0] nxt,
  output logic [AW-1:0] q
);
  localparam int HIW = AW - DW;

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (ld) begin
      q <= ld_val;
    end else if (wr_hi) begin
      q[AW-1:DW] <= wr_data[HIW-1:0];
    end else if (wr_lo) begin
      q[DW-1:0] <= wr_data;
    end else if (upd) begin
      q <= nxt;
    end
  end

  a_r2_full_load: assert property (@(posedge clk) disable iff (rst)
    ld |=> q == $past(ld_val));

  a_r12_byte_beats_step: assert property (@(posedge clk) disable iff (rst)
    (!ld && wr_lo && !wr_hi) |=> (q[DW-1:0] == $past(wr_data)) && (q[AW-1:DW] == $past(q[AW-1:DW])));

  a_r3_hi_keeps_lo: assert property (@(posedge clk) disable iff (rst)
    (!ld && wr_hi) |=> q[DW-1:0] == $past(q[DW-1:0]));

  a_r6_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!ld && !wr_lo && !wr_hi && !upd) |=> $stable(q));
endmodule

// File: rtl/ptr_addr_unit.sv
module ptr_addr_unit #(
  parameter int AW   = 12,
  parameter int DW   = 8,
  parameter int NPTR = 3,
  parameter int SELW = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       acc_en,
  input  logic [SELW-1:0]            acc_sel,
  input  logic [ptr_pkg::MODE_W-1:0] acc_mode,
  input  logic [DW-1:0]              wreg,
  input  logic                       ld_en,
  input  logic                       wr_en,
  input  logic                       wr_hi,
  input  logic [SELW-1:0]            wr_sel,
  input  logic [DW-1:0]              wr_data,
  input  logic [AW-1:0]              ld_val,
  input  logic [SELW-1:0]            rd_sel,
  input  logic                       rd_hi,
  output logic [AW-1:0]              addr_out,
  output logic                       addr_vld,
  output logic [DW-1:0]              rd_data
);
  import ptr_pkg::*;

  localparam int HIW = AW - DW;
  localparam logic [SELW-1:0] LAST = SELW'(NPTR - 1);

  logic [AW-1:0] ptr_q [NPTR];
  logic [AW-1:0] cur;
  logic [AW-1:0] cur_rd;
  logic [AW-1:0] ea;
  logic [AW-1:0] nxt;
  logic          upd;
  logic          acc_ok;
  logic          wr_ok;

  assign acc_ok = acc_en && (acc_sel <= LAST);
  assign wr_ok  = wr_sel <= LAST;
  assign cur    = (acc_sel <= LAST) ? ptr_q[acc_sel] : '0;
  assign cur_rd = (rd_sel <= LAST) ? ptr_q[rd_sel] : '0;

  ptr_calc #(.AW(AW), .DW(DW)) u_calc (
    .cur  (cur),
    .mode (acc_mode),
    .wreg (wreg),
    .ea   (ea),
    .nxt  (nxt),
    .upd  (upd)
  );

  for (genvar i = 0; i < NPTR; i++) begin : g_ptr
    logic hit_w;
    logic hit_a;
    assign hit_w = wr_ok && (wr_sel == SELW'(i));
    assign hit_a = acc_ok && (acc_sel == SELW'(i));

    ptr_reg #(.AW(AW), .DW(DW)) u_reg (
      .clk     (clk),
      .rst     (rst),
      .ld      (hit_w && ld_en),
      .ld_val  (ld_val),
      .wr_lo   (hit_w && wr_en && !wr_hi),
      .wr_hi   (hit_w && wr_en && wr_hi),
      .wr_data (wr_data),
      .upd     (hit_a && upd),
      .nxt     (nxt),
      .q       (ptr_q[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_out <= '0;
      addr_vld <= 1'b0;
      rd_data  <= '0;
    end else begin
      addr_vld <= acc_ok;
      if (acc_ok) addr_out <= ea;
      rd_data  <= rd_hi ? {{(DW-HIW){1'b0}}, cur_rd[AW-1:DW]} : cur_rd[DW-1:0];
    end
  end

  a_r5_valid_follows: assert property (@(posedge clk) disable iff (rst)
    acc_ok |=> addr_vld);

  a_r13_bad_sel_quiet: assert property (@(posedge clk) disable iff (rst)
    (acc_en && acc_sel > LAST) |=> !addr_vld);

  a_r4_hi_upper_zero: assert property (@(posedge clk) disable iff (rst)
    $past(rd_hi) |-> rd_data[DW-1:HIW] == '0);

  a_r7_postinc_step: assert property (@(posedge clk) disable iff (rst)
    (acc_ok && acc_mode == AM_POSTINC && !(wr_ok && wr_sel == acc_sel && (ld_en || wr_en)))
    |=> ptr_q[$past(acc_sel)] == addr_out + AW'(1));

  a_r10_offset_keeps_ptr: assert property (@(posedge clk) disable iff (rst)
    (acc_ok && acc_mode == AM_OFFSET && !(wr_ok && wr_sel == acc_sel && (ld_en || wr_en)))
    |=> ptr_q[$past(acc_sel)] == $past(cur));
endmodule

// File: tb/ptr_addr_unit_test.sv
`timescale 1ns/1ps
module ptr_addr_unit_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        acc_en;
  logic [1:0]  acc_sel;
  logic [2:0]  acc_mode;
  logic [7:0]  wreg;
  logic        ld_en;
  logic        wr_en;
  logic        wr_hi;
  logic [1:0]  wr_sel;
  logic [7:0]  wr_data;
  logic [11:0] ld_val;
  logic [1:0]  rd_sel;
  logic        rd_hi;
  logic [11:0] addr_out;
  logic        addr_vld;
  logic [7:0]  rd_data;

  always #2.5 clk = ~clk;

  ptr_addr_unit uut (
    .clk(clk), .rst(rst), .acc_en(acc_en), .acc_sel(acc_sel), .acc_mode(acc_mode),
    .wreg(wreg), .ld_en(ld_en), .wr_en(wr_en), .wr_hi(wr_hi), .wr_sel(wr_sel),
    .wr_data(wr_data), .ld_val(ld_val), .rd_sel(rd_sel), .rd_hi(rd_hi),
    .addr_out(addr_out), .addr_vld(addr_vld), .rd_data(rd_data)
  );

  int    m [3];
  int    checks = 0;
  int    errors = 0;
  bit    have_exp = 0;
  int    e_vld, e_addr, e_rd;
  string e_tag_a, e_tag_v, e_tag_r;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // One clock: compare last cycle's registered results, then drive and predict.
  task automatic cyc(input bit a_en, input int a_sel, input int a_mode, input int w,
                     input bit l_en, input bit b_en, input bit b_hi, input int w_sel,
                     input int l_val, input int b_dat, input int r_sel, input bit r_hi,
                     input string tag);
    int cur, ea, nv, sw;
    bit step;
    @(negedge clk);
    if (have_exp) begin
      check(e_tag_v, int'(addr_vld), e_vld);
      if (e_vld != 0) check(e_tag_a, int'(addr_out), e_addr);
      check(e_tag_r, int'(rd_data), e_rd);
    end
    acc_en = a_en; acc_sel = 2'(a_sel); acc_mode = 3'(a_mode); wreg = 8'(w);
    ld_en = l_en; wr_en = b_en; wr_hi = b_hi; wr_sel = 2'(w_sel);
    ld_val = 12'(l_val); wr_data = 8'(b_dat); rd_sel = 2'(r_sel); rd_hi = r_hi;

    // read-back reflects pointer before this edge (R4); select 3 reads zero (R13)
    if (r_sel < 3) e_rd = r_hi ? (m[r_sel] >> 8) : (m[r_sel] & 255);
    else e_rd = 0;
    e_tag_r = (tag != "") ? tag : ((r_sel < 3) ? "R4" : "R13");

    e_vld   = (a_en && a_sel < 3) ? 1 : 0;
    e_tag_v = (tag != "") ? tag : ((a_sel < 3) ? "R5" : "R13");
    e_tag_a = tag;
    step = 0;
    nv = 0;
    if (e_vld != 0) begin
      cur = m[a_sel];
      sw  = (w > 127) ? w - 256 : w;
      case (a_mode)
        1: begin ea = cur; nv = (cur + 1) % 4096; step = 1; if (tag == "") e_tag_a = "R7"; end
        2: begin ea = cur; nv = (cur + 4095) % 4096; step = 1; if (tag == "") e_tag_a = "R8"; end
        3: begin ea = (cur + 1) % 4096; nv = ea; step = 1; if (tag == "") e_tag_a = "R9"; end
        4: begin ea = (cur + sw + 4096) % 4096; if (tag == "") e_tag_a = "R10"; end
        default: begin ea = cur; if (tag == "") e_tag_a = "R6"; end
      endcase
      e_addr = ea;
    end
    // priority: load over byte write over access step (R12)
    if (w_sel < 3 && l_en) m[w_sel] = l_val % 4096;
    else if (w_sel < 3 && b_en) begin
      if (b_hi) m[w_sel] = ((b_dat % 16) << 8) | (m[w_sel] & 255);
      else      m[w_sel] = (m[w_sel] & 'hF00) | (b_dat & 255);
      if (step && a_sel != w_sel) m[a_sel] = nv;
    end else if (step) m[a_sel] = nv;
    if (step && w_sel < 3 && l_en && a_sel != w_sel) m[a_sel] = nv;
    have_exp = 1;
  endtask

  task automatic acc(input int s, input int md, input int w, input string tag);
    cyc(1, s, md, w, 0, 0, 0, 3, 0, 0, s, 0, tag);
  endtask
  task automatic load(input int s, input int v, input string tag);
    cyc(0, 0, 0, 0, 1, 0, 0, s, v, 0, s, 1, tag);
  endtask
  task automatic rd(input int s, input bit hi, input string tag);
    cyc(0, 0, 0, 0, 0, 0, 0, 3, 0, 0, s, hi, tag);
  endtask

  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    rst = 1; acc_en = 0; acc_sel = 0; acc_mode = 0; wreg = 0; ld_en = 0; wr_en = 0;
    wr_hi = 0; wr_sel = 0; wr_data = 0; ld_val = 0; rd_sel = 0; rd_hi = 0;
    for (int i = 0; i < 3; i++) m[i] = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(posedge clk);
    @(negedge clk);
    check("R1 vld", int'(addr_vld), 0);
    check("R1 rd", int'(rd_data), 0);
    for (int i = 0; i < 3; i++) begin
      rd(i, 0, "R1");
      rd(i, 1, "R1");
    end

    // R2 load, R7 back-to-back post-increment across a bank start
    load(0, 'h100, "R2");
    for (int i = 0; i < 4; i++) acc(0, 1, 0, "R7");
    rd(0, 0, "R7");
    // R8 and R11: decrement below zero, pre-increment past the top
    load(1, 'h000, "R2");
    acc(1, 2, 0, "R11");
    rd(1, 1, "R11");
    acc(1, 3, 0, "R11");
    acc(1, 2, 0, "R8");
    acc(1, 0, 0, "R8");
    // R3 byte writes, R4 high byte upper nibble zero
    cyc(0, 0, 0, 0, 0, 1, 1, 2, 0, 'hA5, 2, 1, "R3");
    cyc(0, 0, 0, 0, 0, 1, 0, 2, 0, 'h3C, 2, 1, "R3");
    rd(2, 1, "R4");
    rd(2, 0, "R4");
    // R10 signed offset, pointer kept; R6 plain and unused mode codes
    acc(2, 4, 'h80, "R10");
    acc(2, 4, 'h7F, "R10");
    acc(2, 0, 0, "R6");
    acc(2, 6, 0, "R6");
    load(1, 'hFFF, "R2");
    acc(1, 4, 'h01, "R11");
    acc(0, 3, 0, "R9");
    acc(0, 0, 0, "R9");
    // R12 collisions on one pointer
    cyc(1, 0, 1, 0, 1, 0, 0, 0, 'h2AB, 0, 0, 0, "R12");
    acc(0, 0, 0, "R12");
    cyc(1, 1, 2, 0, 0, 1, 0, 1, 0, 'h77, 1, 0, "R12");
    rd(1, 0, "R12");
    rd(1, 1, "R12");
    cyc(0, 0, 0, 0, 1, 1, 0, 2, 'h456, 'h99, 2, 0, "R12");
    acc(2, 0, 0, "R12");
    // R13 select value 3 everywhere
    acc(3, 1, 0, "R13");
    cyc(0, 0, 0, 0, 1, 1, 1, 3, 'hEEE, 'hFF, 3, 1, "R13");
    for (int i = 0; i < 3; i++) rd(i, 0, "R13");

    for (int n = 0; n < 3000; n++) begin
      logic [31:0] r1, r2;
      r1 = $urandom;
      r2 = $urandom;
      cyc(r1[0], int'(r1[2:1]), int'(r1[5:3]), int'(r1[13:6]), r1[14] & r1[15],
          r1[16], r1[17], int'(r1[19:18]), int'(r2[11:0]), int'(r2[19:12]),
          int'(r1[21:20]), r1[22], "");
    end
    rd(0, 0, "");
    summary();
    $finish;
  end
endmodule